// File: doc/BRIEF.md
# Scalar Double-Precision Predicate Comparator

This block evaluates one of 32 comparison predicates on the low 64-bit double-precision value of each of two 128-bit sources. A predicate is built from four parts: a relation (equal, less, less-or-equal, their negations and their mirrored forms), a forced constant (always true or always false), a rule for unordered pairs, and a quiet or signaling exception attribute.

The outcome is written in one of three forms. The first form is an all-ones or all-zeros 64-bit lane mask, using only the low three predicate bits, with the upper lane passed through from the first source. The second form is the same lane mask using all five predicate bits. The third form is a single result bit, gated by a writemask bit, with every other bit cleared.

Alongside the result the block reports an invalid-operation flag and a denormal-operand flag. An exception-suppress input clears both flags. Every output is registered, so results appear one clock after the inputs are presented.

Top module: `fp64_pred_cmp`

## Requirements
- R1: For a pair with no NaN, predicate code c (low four bits b = c[3:0]) returns the following relation of src_a to src_b:
  - b=0 or 8: equal. b=4 or 12: not equal.
  - b=1: less. b=5: not less.
  - b=2: less-or-equal. b=6: not less-or-equal.
  - b=9: not greater-or-equal. b=13: greater-or-equal.
  - b=10: not greater. b=14: greater.
  - b=3 and b=11: false. b=7 and b=15: true.
  - +0 and -0 compare equal, and ordering follows the real values, including infinities and subnormals.
- R2: When either low operand is a NaN (exponent all ones, fraction nonzero), the result is true for b in {3,4,5,6,8,9,10,15} and false for every other b.
- R3: Codes 16 to 31 give the same result as code minus 16. They differ only in the quiet/signaling attribute, which is inverted.
- R4: In legacy format (mode=0) only pred[2:0] selects the predicate, and pred[4:3] has no effect on any output.
- R5: In lane formats (mode=0 or mode=1), res[63:0] is all ones when the predicate holds and all zeros when it does not, and res[127:64] equals src_a[127:64].
- R6: In mask format (mode=2 or mode=3), res[0] is the predicate outcome when mask_en=0 or wmask_bit=1. Otherwise res[0] is 0. res[127:1] is always 0.
- R7: flag_invalid is 1 when either low operand is a signaling NaN (fraction MSB 0) and sae=0.
- R8: A quiet NaN operand (fraction MSB 1) raises flag_invalid only under a signaling predicate. The signaling predicates are b in {1,2,5,6,9,10,13,14} with c[4]=0, and the other b values with c[4]=1.
- R9: flag_denorm is 1 when either low operand is subnormal (exponent zero, fraction nonzero) and sae=0. The writemask does not affect either flag.
- R10: When sae=1, flag_invalid and flag_denorm are both 0.
- R11: The inputs sampled at a clock edge appear on all outputs after that edge. While rst is high, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_a | input | 128 | First source; low lane is the left operand |
| src_b | input | 128 | Second source; low lane is the right operand |
| pred | input | 5 | Comparison predicate code |
| mode | input | 2 | Result format: 0 legacy lane, 1 vector lane, 2 or 3 mask bit |
| mask_en | input | 1 | Writemask in use (mask format) |
| wmask_bit | input | 1 | Writemask bit for the result bit |
| sae | input | 1 | Suppress all exception flags |
| res | output | 128 | Formatted result |
| flag_invalid | output | 1 | Invalid-operation flag |
| flag_denorm | output | 1 | Denormal-operand flag |

## Verification
The bench builds the block with its default parameters: an 11-bit exponent, a 52-bit fraction and two lanes. With these values, the low-lane operand is an ordinary double, so the reference model can order non-NaN pairs through real arithmetic. That lets the model cover both zero signs, subnormals, infinities, quiet NaNs and signaling NaNs. All 32 predicate codes are swept against every operand pair in all four mode encodings, while the writemask and suppress inputs are toggled. This sweep reaches the ignored predicate bits in legacy format and every masked-off case.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int PRED_W     = 5;
  localparam int LEG_PRED_W = 3;

  typedef enum logic [1:0] {
    FMT_LEGACY = 2'd0,
    FMT_VEC    = 2'd1,
    FMT_KMASK  = 2'd2,
    FMT_KMASK2 = 2'd3
  } fmt_e;

  typedef struct packed {
    logic nan;
    logic qnan;
    logic snan;
    logic zero;
    logic sub;
  } fpcls_t;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
  import fpcmp_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic [EXP_W+MAN_W:0] val,
  output fpcls_t               cls
);
  localparam int LANE_W = 1 + EXP_W + MAN_W;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic exp_max, exp_zero, man_nz;

  assign exp_f    = val[LANE_W-2 -: EXP_W];
  assign man_f    = val[MAN_W-1:0];
  assign exp_max  = &exp_f;
  assign exp_zero = ~|exp_f;
  assign man_nz   = |man_f;

  always_comb begin
    cls.nan  = exp_max & man_nz;
    cls.qnan = exp_max & man_nz & man_f[MAN_W-1];
    cls.snan = exp_max & man_nz & ~man_f[MAN_W-1];
    cls.zero = exp_zero & ~man_nz;
    cls.sub  = exp_zero & man_nz;
  end
endmodule

// File: rtl/fpcmp_relation.sv
module fpcmp_relation #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic [EXP_W+MAN_W:0] op_a,
  input  logic [EXP_W+MAN_W:0] op_b,
  output logic                 lt,
  output logic                 eq
);
  localparam int LANE_W = 1 + EXP_W + MAN_W;

  logic [LANE_W-2:0] mag_a, mag_b;
  logic sgn_a, sgn_b, both_zero;

  assign mag_a     = op_a[LANE_W-2:0];
  assign mag_b     = op_b[LANE_W-2:0];
  assign sgn_a     = op_a[LANE_W-1];
  assign sgn_b     = op_b[LANE_W-1];
  assign both_zero = ~|mag_a & ~|mag_b;

  always_comb begin
    eq = both_zero | (op_a == op_b);
    if (both_zero)          lt = 1'b0;
    else if (sgn_a != sgn_b) lt = sgn_a;
    else if (!sgn_a)        lt = mag_a < mag_b;
    else                    lt = mag_a > mag_b;
  end
endmodule

// File: rtl/fpcmp_predicate.sv
module fpcmp_predicate
  import fpcmp_pkg::*;
(
  input  logic [PRED_W-1:0] code,
  input  logic              lt,
  input  logic              eq,
  input  logic              unord,
  output logic              outcome,
  output logic              signaling
);
  logic [3:0] base;
  logic       unord_res;
  logic       ord_res;
  logic       gt;

  assign base      = code[3:0];
  assign gt        = ~lt & ~eq;
  // Unordered pairs: true for bases 3,4,5,6,8,9,10,15
  assign unord_res = base[3] ^ base[2] ^ (&base[1:0]);
  // Bases whose two low bits differ are the signaling family; bit 4 flips it
  assign signaling = (base[0] ^ base[1]) ^ code[4];

  always_comb begin
    unique case (base)
      4'd0, 4'd8:   ord_res = eq;
      4'd1, 4'd9:   ord_res = lt;
      4'd2, 4'd10:  ord_res = lt | eq;
      4'd4, 4'd12:  ord_res = ~eq;
      4'd5, 4'd13:  ord_res = gt | eq;
      4'd6, 4'd14:  ord_res = gt;
      4'd7, 4'd15:  ord_res = 1'b1;
      default:      ord_res = 1'b0;
    endcase
    outcome = unord ? unord_res : ord_res;
  end

  // R1: the relation inputs never claim both less and equal
  always_comb begin
    p_rel_excl_r1: assert (!(lt && eq));
  end
endmodule

// File: rtl/fp64_pred_cmp.sv
module fp64_pred_cmp
  import fpcmp_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int LANES = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [LANES*(1+EXP_W+MAN_W)-1:0] src_a,
  input  logic [LANES*(1+EXP_W+MAN_W)-1:0] src_b,
  input  logic [PRED_W-1:0]               pred,
  input  logic [1:0]                      mode,
  input  logic                            mask_en,
  input  logic                            wmask_bit,
  input  logic                            sae,
  output logic [LANES*(1+EXP_W+MAN_W)-1:0] res,
  output logic                            flag_invalid,
  output logic                            flag_denorm
);
  localparam int LANE_W = 1 + EXP_W + MAN_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [LANE_W-1:0] opnd [2];
  fpcls_t            cls  [2];

  assign opnd[0] = src_a[LANE_W-1:0];
  assign opnd[1] = src_b[LANE_W-1:0];

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .val (opnd[i]),
      .cls (cls[i])
    );
  end

  logic rel_lt, rel_eq;
  fpcmp_relation #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_rel (
    .op_a (opnd[0]),
    .op_b (opnd[1]),
    .lt   (rel_lt),
    .eq   (rel_eq)
  );

  fmt_e              fmt;
  logic [PRED_W-1:0] eff_code;
  logic              unord, outcome, sig_pred;
  logic              any_snan, any_qnan, any_sub;

  assign fmt      = fmt_e'(mode);
  assign eff_code = (fmt == FMT_LEGACY)
                  ? {{(PRED_W-LEG_PRED_W){1'b0}}, pred[LEG_PRED_W-1:0]}
                  : pred;
  assign unord    = cls[0].nan  | cls[1].nan;
  assign any_snan = cls[0].snan | cls[1].snan;
  assign any_qnan = cls[0].qnan | cls[1].qnan;
  assign any_sub  = cls[0].sub  | cls[1].sub;

  fpcmp_predicate u_pred (
    .code      (eff_code),
    .lt        (rel_lt),
    .eq        (rel_eq),
    .unord     (unord),
    .outcome   (outcome),
    .signaling (sig_pred)
  );

  logic [DATA_W-1:0] res_d;
  logic              inv_d, den_d;

  always_comb begin
    if (mode[1]) begin
      res_d    = '0;
      res_d[0] = outcome & (~mask_en | wmask_bit);
    end else begin
      res_d = {src_a[DATA_W-1:LANE_W], {LANE_W{outcome}}};
    end
    inv_d = ~sae & (any_snan | (any_qnan & sig_pred));
    den_d = ~sae & any_sub;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res          <= '0;
      flag_invalid <= 1'b0;
      flag_denorm  <= 1'b0;
    end else begin
      res          <= res_d;
      flag_invalid <= inv_d;
      flag_denorm  <= den_d;
    end
  end

  // R6: mask format keeps every bit above bit 0 clear
  p_kmask_upper_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode[1])) |-> (res[DATA_W-1:1] == '0));

  // R6: masked-off result bit is zero
  p_masked_off_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode[1]) && $past(mask_en) && !$past(wmask_bit))
      |-> (res == '0));

  // R5: lane formats produce a uniform lane mask
  p_lane_fill_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mode[1]))
      |-> ((res[LANE_W-1:0] == '0) || (res[LANE_W-1:0] == '1)));

  // R5: upper lane passes through from the first source
  p_upper_copy_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mode[1]))
      |-> (res[DATA_W-1:LANE_W] == $past(src_a[DATA_W-1:LANE_W])));

  // R10: suppression silences both flags
  p_sae_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sae)) |-> (!flag_invalid && !flag_denorm));

  // R7: a signaling NaN always raises invalid when not suppressed
  p_snan_inv_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(any_snan) && !$past(sae)) |-> flag_invalid);

  // R11: outputs are clear right after a reset cycle
  p_reset_clear_r11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (res == '0 && !flag_invalid && !flag_denorm));
endmodule

// File: tb/fp64_pred_cmp_bench.sv
`timescale 1ns/1ps
module fp64_pred_cmp_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic [127:0] src_a, src_b;
  logic [4:0]   pred;
  logic [1:0]   mode;
  logic         mask_en, wmask_bit, sae;
  logic [127:0] res;
  logic         flag_invalid, flag_denorm;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  fp64_pred_cmp u_fp64_pred_cmp (
    .clk(clk), .rst(rst), .src_a(src_a), .src_b(src_b), .pred(pred),
    .mode(mode), .mask_en(mask_en), .wmask_bit(wmask_bit), .sae(sae),
    .res(res), .flag_invalid(flag_invalid), .flag_denorm(flag_denorm)
  );

  function automatic bit is_nan(input logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
  endfunction
  function automatic bit is_snan(input logic [63:0] x);
    return is_nan(x) && !x[51];
  endfunction
  function automatic bit is_qnan(input logic [63:0] x);
    return is_nan(x) && x[51];
  endfunction
  function automatic bit is_sub(input logic [63:0] x);
    return (x[62:52] == 0) && (x[51:0] != 0);
  endfunction

  // Reference outcome of the predicate for the low operands
  function automatic bit ref_outcome(input logic [63:0] a, input logic [63:0] b,
                                     input int code);
    int  base;
    real ra, rb;
    base = code % 16;
    if (is_nan(a) || is_nan(b))
      return base inside {3, 4, 5, 6, 8, 9, 10, 15};
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    case (base)
      0, 8:   return ra == rb;
      1:      return ra < rb;
      2:      return ra <= rb;
      4, 12:  return ra != rb;
      5:      return !(ra < rb);
      6:      return !(ra <= rb);
      9:      return !(ra >= rb);
      10:     return !(ra > rb);
      13:     return ra >= rb;
      14:     return ra > rb;
      7, 15:  return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check_cycle(input logic [127:0] a, input logic [127:0] b,
                             input int p, input int m, input bit me,
                             input bit wb, input bit s);
    int           code;
    bit           outc, sig, exp_inv, exp_den;
    logic [127:0] exp_res;
    string        tag;
    @(negedge clk);
    src_a = a; src_b = b; pred = p[4:0]; mode = m[1:0];
    mask_en = me; wmask_bit = wb; sae = s;
    code = (m == 0) ? (p % 8) : p;
    outc = ref_outcome(a[63:0], b[63:0], code);
    sig  = ((code % 16) inside {1, 2, 5, 6, 9, 10, 13, 14}) ^ (code >= 16);
    if (m >= 2) begin
      exp_res    = '0;
      exp_res[0] = outc && (!me || wb);
    end else begin
      exp_res = {a[127:64], {64{outc}}};
    end
    exp_inv = !s && (is_snan(a[63:0]) || is_snan(b[63:0]) ||
                     (sig && (is_qnan(a[63:0]) || is_qnan(b[63:0]))));
    exp_den = !s && (is_sub(a[63:0]) || is_sub(b[63:0]));
    @(posedge clk);
    @(negedge clk);
    // result
    n_checks++;
    if (res !== exp_res) begin
      if (m >= 2) tag = "R6";
      else if (res[127:64] !== exp_res[127:64]) tag = "R5";
      else if (is_nan(a[63:0]) || is_nan(b[63:0])) tag = "R2";
      else if (m == 0 && p >= 8) tag = "R4";
      else if (p >= 16) tag = "R3";
      else tag = "R1";
      n_fail++;
      $display("FAIL %s res pred=%0d mode=%0d actual=%h expected=%h",
               tag, p, m, res, exp_res);
    end
    // invalid flag
    n_checks++;
    if (flag_invalid !== exp_inv) begin
      if (s) tag = "R10";
      else if (is_snan(a[63:0]) || is_snan(b[63:0])) tag = "R7";
      else tag = "R8";
      n_fail++;
      $display("FAIL %s invalid pred=%0d mode=%0d actual=%0b expected=%0b",
               tag, p, m, flag_invalid, exp_inv);
    end
    // denormal flag
    n_checks++;
    if (flag_denorm !== exp_den) begin
      tag = s ? "R10" : "R9";
      n_fail++;
      $display("FAIL %s denorm pred=%0d mode=%0d actual=%0b expected=%0b",
               tag, p, m, flag_denorm, exp_den);
    end
  endtask

  logic [63:0] ops_a [14];
  logic [63:0] ops_b [14];

  initial begin
    // pairs: normals, mirrored, equal, negatives, signed zeros, subnormals,
    // quiet/signaling NaNs, infinities
    ops_a[0]  = 64'h3FF0000000000000; ops_b[0]  = 64'h4000000000000000;
    ops_a[1]  = 64'h4000000000000000; ops_b[1]  = 64'h3FF0000000000000;
    ops_a[2]  = 64'h3FF0000000000000; ops_b[2]  = 64'h3FF0000000000000;
    ops_a[3]  = 64'hBFF0000000000000; ops_b[3]  = 64'hC000000000000000;
    ops_a[4]  = 64'hC000000000000000; ops_b[4]  = 64'hBFF0000000000000;
    ops_a[5]  = 64'h0000000000000000; ops_b[5]  = 64'h8000000000000000;
    ops_a[6]  = 64'hBFF0000000000000; ops_b[6]  = 64'h3FF0000000000000;
    ops_a[7]  = 64'h0000000000000001; ops_b[7]  = 64'h0000000000000000;
    ops_a[8]  = 64'h8000000000000001; ops_b[8]  = 64'h0000000000000001;
    ops_a[9]  = 64'h7FF8000000000000; ops_b[9]  = 64'h3FF0000000000000;
    ops_a[10] = 64'h3FF0000000000000; ops_b[10] = 64'h7FF0000000000001;
    ops_a[11] = 64'h7FF0000000000000; ops_b[11] = 64'h4000000000000000;
    ops_a[12] = 64'hFFF0000000000000; ops_b[12] = 64'hC000000000000000;
    ops_a[13] = 64'h7FF8000000000000; ops_b[13] = 64'hFFF8000000000000;

    rst = 1'b1; src_a = '0; src_b = '0; pred = '0; mode = '0;
    mask_en = 1'b0; wmask_bit = 1'b0; sae = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: outputs cleared while in reset
    n_checks++;
    if (res !== '0 || flag_invalid !== 1'b0 || flag_denorm !== 1'b0) begin
      n_fail++;
      $display("FAIL R11 reset actual=%h/%0b/%0b expected=0/0/0",
               res, flag_invalid, flag_denorm);
    end
    rst = 1'b0;

    for (int i = 0; i < 14; i++)
      for (int m = 0; m < 4; m++)
        for (int p = 0; p < 32; p++)
          check_cycle({32'hA5C3_0F1E, 24'h0, 8'(i), ops_a[i]},
                      {32'h1234_5678, 24'h0, 8'(p), ops_b[i]},
                      p, m, p[0], p[1], (p % 5) == 3);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule